// File: doc/BRIEF.md
# CAN controller mode and reset sequencer

This block holds the mode-control bits of a CAN protocol controller and sequences the controller between its disabled, frozen and running states. Host software writes a small control word (module disable, freeze enable, halt, soft-reset request) in the host clock domain. The block reports soft-reset pending, freeze acknowledge and not-ready status back in that domain. It drives an enable and a one-cycle soft-reset pulse to a protocol engine that runs on a separate CAN clock.

A soft reset is a polled, four-phase request/acknowledge across the two clock domains. Software sets the request bit and then polls it until it reads back as 0. While the reset is pending the controller is forced into freeze mode. Freeze mode stops the protocol engine and holds the transmit pin recessive. After freeze is left, not-ready stays set until the engine reports an idle bus. Configuration of the rest of the controller is expected only after the module has been enabled and then frozen.

Top module: `can_mode_seq`

## Requirements
- R1: After reset, mdis_o, halt_o, frz_en_o and not_rdy_o read 1, while srst_o, frz_ack_o and eng_en_o read 0. tx_o is 1 (recessive).
- R2: When ctl_we_i is high with ctl_srst_i = 0 and no soft reset is pending, mdis_o, halt_o and frz_en_o take the written values on the next host clock edge.
- R3: A write with ctl_srst_i = 1 sets srst_o on the next host edge. The same write forces halt_o and frz_en_o to 1 and leaves mdis_o unchanged, so the module leaves soft reset frozen.
- R4: While a soft reset is pending, eng_srst_o pulses in the CAN domain. srst_o stays 1 for at least 3 host cycles and clears by itself once the acknowledge has returned.
- R5: Control writes made while srst_o is 1 are ignored. mdis_o, halt_o and frz_en_o keep their values.
- R6: With mdis_o = 0 and both halt_o and frz_en_o at 1, eng_en_o drops to 0 and frz_ack_o and not_rdy_o both become 1. frz_ack_o is never 1 while not_rdy_o is 0.
- R7: While eng_en_o is 0, tx_o is 1 whatever tx_eng_i is. While eng_en_o is 1, tx_o follows tx_eng_i.
- R8: Clearing halt_o leaves freeze. eng_en_o rises, and frz_ack_o clears once the enable has been seen back in the host domain. not_rdy_o stays 1 until bus_idle_i is reported high by the enabled engine.
- R9: With mdis_o = 1, eng_en_o is 0, not_rdy_o is 1 and frz_ack_o is 0.
- R10: halt_o = 1 with frz_en_o = 0 does not freeze the module. eng_en_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| can_clk_i | input | 1 | Protocol engine clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_mdis_i | input | 1 | Written module-disable value |
| ctl_frz_en_i | input | 1 | Written freeze-enable value |
| ctl_halt_i | input | 1 | Written halt value |
| ctl_srst_i | input | 1 | Soft-reset request (1 = start) |
| mdis_o | output | 1 | Module disable state |
| frz_en_o | output | 1 | Freeze enable state |
| halt_o | output | 1 | Halt state |
| srst_o | output | 1 | Soft reset pending |
| frz_ack_o | output | 1 | Freeze acknowledge |
| not_rdy_o | output | 1 | Not ready (disabled, frozen or not yet bus-idle) |
| eng_en_o | output | 1 | Protocol engine enable, CAN domain |
| eng_srst_o | output | 1 | One-cycle engine soft reset, CAN domain |
| bus_idle_i | input | 1 | Engine has seen 11 recessive bits, CAN domain |
| tx_eng_i | input | 1 | Engine transmit bit, CAN domain |
| tx_o | output | 1 | Transmit pin |

## Verification
On every host cycle the assertions check that a rising soft-reset flag comes with halt and freeze enable forced on, and that the control bits cannot move while a reset is pending. They also check that freeze acknowledge always implies not-ready, that not-ready only falls once freeze acknowledge has gone, and that a disabled module never shows freeze acknowledge. Some behaviour spans both clocks, and only the directed scenarios show it: the engine enable actually dropping and returning, the soft-reset pulse reaching the engine, the soft-reset flag clearing by itself, not-ready waiting for the idle report, and the transmit pin being forced recessive.

// File: rtl/can_mode_pkg.sv
`timescale 1ns/1ps
package can_mode_pkg;
  typedef struct packed {
    logic mdis;
    logic halt;
    logic frz_en;
  } mode_cfg_t;

  localparam mode_cfg_t CFG_RST = '{mdis: 1'b1, halt: 1'b1, frz_en: 1'b1};
endpackage

// File: rtl/cm_sync.sv
`timescale 1ns/1ps
module cm_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/cm_host.sv
`timescale 1ns/1ps
module cm_host
  import can_mode_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      we_i,
  input  mode_cfg_t wcfg_i,
  input  logic      wsrst_i,
  input  logic      ack_s_i,
  input  logic      en_s_i,
  input  logic      idle_s_i,
  output mode_cfg_t cfg_o,
  output logic      srst_o,
  output logic      run_o,
  output logic      frz_ack_o,
  output logic      not_rdy_o
);
  mode_cfg_t cfg_q;
  logic      srst_q, frz_ack_q, not_rdy_q;
  logic      accept, frz_req;

  // no writes while a handshake is in flight in either phase
  assign accept  = we_i & ~srst_q & ~ack_s_i;
  assign frz_req = ~cfg_q.mdis & cfg_q.halt & cfg_q.frz_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_RST;
      srst_q <= 1'b0;
    end else if (accept) begin
      if (wsrst_i) begin
        srst_q        <= 1'b1;
        cfg_q.halt    <= 1'b1;
        cfg_q.frz_en  <= 1'b1;
      end else begin
        cfg_q <= wcfg_i;
      end
    end else if (srst_q && ack_s_i) begin
      srst_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frz_ack_q <= 1'b0;
      not_rdy_q <= 1'b1;
    end else begin
      if (cfg_q.mdis || en_s_i)  frz_ack_q <= 1'b0;
      else if (frz_req)          frz_ack_q <= 1'b1;
      if (!en_s_i)               not_rdy_q <= 1'b1;
      else if (idle_s_i)         not_rdy_q <= 1'b0;
    end
  end

  assign cfg_o     = cfg_q;
  assign srst_o    = srst_q;
  assign run_o     = ~cfg_q.mdis & ~frz_req & ~srst_q;
  assign frz_ack_o = frz_ack_q;
  assign not_rdy_o = not_rdy_q;
endmodule

// File: rtl/cm_eng.sv
`timescale 1ns/1ps
module cm_eng (
  input  logic can_clk_i,
  input  logic rst_ni,
  input  logic req_s_i,
  input  logic run_s_i,
  input  logic bus_idle_i,
  input  logic tx_eng_i,
  output logic ack_o,
  output logic en_o,
  output logic srst_o,
  output logic idle_o,
  output logic tx_o
);
  logic ack_q, en_q, srst_q, idle_q;

  always_ff @(posedge can_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      en_q   <= 1'b0;
      srst_q <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      ack_q  <= req_s_i;
      srst_q <= req_s_i & ~ack_q;
      en_q   <= run_s_i & ~req_s_i;
      idle_q <= bus_idle_i & en_q;
    end
  end

  assign ack_o  = ack_q;
  assign en_o   = en_q;
  assign srst_o = srst_q;
  assign idle_o = idle_q;
  assign tx_o   = en_q ? tx_eng_i : 1'b1;
endmodule

// File: rtl/can_mode_seq.sv
`timescale 1ns/1ps
module can_mode_seq
  import can_mode_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic can_clk_i,
  input  logic rst_ni,
  input  logic ctl_we_i,
  input  logic ctl_mdis_i,
  input  logic ctl_frz_en_i,
  input  logic ctl_halt_i,
  input  logic ctl_srst_i,
  output logic mdis_o,
  output logic frz_en_o,
  output logic halt_o,
  output logic srst_o,
  output logic frz_ack_o,
  output logic not_rdy_o,
  output logic eng_en_o,
  output logic eng_srst_o,
  input  logic bus_idle_i,
  input  logic tx_eng_i,
  output logic tx_o
);
  mode_cfg_t wcfg, cfg;
  logic srst_req, run_req;
  logic req_s, run_s, ack_c, en_c, idle_c, ack_s, en_s, idle_s;

  assign wcfg = '{mdis: ctl_mdis_i, halt: ctl_halt_i, frz_en: ctl_frz_en_i};

  cm_host u_host (
    .clk_i, .rst_ni,
    .we_i(ctl_we_i), .wcfg_i(wcfg), .wsrst_i(ctl_srst_i),
    .ack_s_i(ack_s), .en_s_i(en_s), .idle_s_i(idle_s),
    .cfg_o(cfg), .srst_o(srst_req), .run_o(run_req),
    .frz_ack_o, .not_rdy_o
  );

  // host -> CAN
  cm_sync #(.STAGES(SYNC_STAGES)) u_sync_req (.clk_i(can_clk_i), .rst_ni, .d_i(srst_req), .q_o(req_s));
  cm_sync #(.STAGES(SYNC_STAGES)) u_sync_run (.clk_i(can_clk_i), .rst_ni, .d_i(run_req),  .q_o(run_s));
  // CAN -> host
  cm_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (.clk_i, .rst_ni, .d_i(ack_c),  .q_o(ack_s));
  cm_sync #(.STAGES(SYNC_STAGES)) u_sync_en  (.clk_i, .rst_ni, .d_i(en_c),   .q_o(en_s));
  cm_sync #(.STAGES(SYNC_STAGES)) u_sync_idl (.clk_i, .rst_ni, .d_i(idle_c), .q_o(idle_s));

  cm_eng u_eng (
    .can_clk_i, .rst_ni,
    .req_s_i(req_s), .run_s_i(run_s), .bus_idle_i, .tx_eng_i,
    .ack_o(ack_c), .en_o(en_c), .srst_o(eng_srst_o), .idle_o(idle_c), .tx_o
  );

  assign mdis_o   = cfg.mdis;
  assign halt_o   = cfg.halt;
  assign frz_en_o = cfg.frz_en;
  assign srst_o   = srst_req;
  assign eng_en_o = en_c;
endmodule

// File: rtl/can_mode_seq_chk.sv
`timescale 1ns/1ps
module can_mode_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mdis_o,
  input logic frz_en_o,
  input logic halt_o,
  input logic srst_o,
  input logic frz_ack_o,
  input logic not_rdy_o
);
  AST_SRST_FORCES_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(srst_o) |-> (halt_o && frz_en_o)); // R3

  AST_SRST_HOLDS_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (srst_o && $past(srst_o)) |-> $stable({mdis_o, halt_o, frz_en_o})); // R5

  AST_ACK_IMPLIES_NOTRDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frz_ack_o |-> not_rdy_o); // R6

  AST_READY_AFTER_UNFREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(not_rdy_o) |-> !frz_ack_o); // R8

  AST_MDIS_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdis_o && $past(mdis_o)) |-> !frz_ack_o); // R9
endmodule

bind can_mode_seq can_mode_seq_chk u_chk (.*);

// File: tb/can_mode_seq_tb.sv
`timescale 1ns/1ps
module can_mode_seq_tb;
  logic clk_i = 1'b0, can_clk_i = 1'b0, rst_ni = 1'b0;
  logic ctl_we_i = 1'b0, ctl_mdis_i = 1'b0, ctl_frz_en_i = 1'b0, ctl_halt_i = 1'b0, ctl_srst_i = 1'b0;
  logic bus_idle_i = 1'b0, tx_eng_i = 1'b1;
  logic mdis_o, frz_en_o, halt_o, srst_o, frz_ack_o, not_rdy_o, eng_en_o, eng_srst_o, tx_o;
  int n_chk = 0, n_fail = 0, srst_pulses = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;
  always #3 can_clk_i = ~can_clk_i;

  can_mode_seq u_dut (.*);

  always @(negedge can_clk_i) if (eng_srst_o) srst_pulses++;

  task automatic chk(input logic act, input logic exp, input string r);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", r, act, exp);
    end
  endtask

  task automatic wr(input logic m, input logic f, input logic h, input logic s);
    @(negedge clk_i);
    ctl_we_i = 1'b1; ctl_mdis_i = m; ctl_frz_en_i = f; ctl_halt_i = h; ctl_srst_i = s;
    @(negedge clk_i);
    ctl_we_i = 1'b0; ctl_srst_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic t_reset();
    idle(1);
    chk(mdis_o, 1'b1, "R1 mdis");   chk(halt_o, 1'b1, "R1 halt");
    chk(frz_en_o, 1'b1, "R1 frz_en"); chk(not_rdy_o, 1'b1, "R1 not_rdy");
    chk(srst_o, 1'b0, "R1 srst");   chk(frz_ack_o, 1'b0, "R1 frz_ack");
    chk(eng_en_o, 1'b0, "R1 eng_en"); chk(tx_o, 1'b1, "R1 tx");
    idle(20);
    chk(frz_ack_o, 1'b0, "R9 no ack while disabled");
    chk(not_rdy_o, 1'b1, "R9 not_rdy while disabled");
    chk(eng_en_o, 1'b0, "R9 engine off while disabled");
  endtask

  task automatic t_enable();
    wr(1'b0, 1'b1, 1'b0, 1'b0);
    chk(mdis_o, 1'b0, "R2 mdis written"); chk(halt_o, 1'b0, "R2 halt written");
    chk(frz_en_o, 1'b1, "R2 frz_en written");
    idle(30);
    chk(eng_en_o, 1'b1, "R8 engine enabled");
    chk(not_rdy_o, 1'b1, "R8 not_rdy until idle");
    tx_eng_i = 1'b0; idle(1);
    chk(tx_o, 1'b0, "R7 tx follows engine 0");
    tx_eng_i = 1'b1; idle(1);
    chk(tx_o, 1'b1, "R7 tx follows engine 1");
    bus_idle_i = 1'b1; idle(30);
    chk(not_rdy_o, 1'b0, "R8 ready after idle");
    chk(frz_ack_o, 1'b0, "R8 no ack while running");
  endtask

  task automatic t_halt_only();
    wr(1'b0, 1'b0, 1'b1, 1'b0);
    idle(30);
    chk(eng_en_o, 1'b1, "R10 halt without freeze enable");
    chk(frz_ack_o, 1'b0, "R10 no ack");
  endtask

  task automatic t_freeze();
    wr(1'b0, 1'b1, 1'b1, 1'b0);
    idle(30);
    chk(eng_en_o, 1'b0, "R6 engine stopped");
    chk(frz_ack_o, 1'b1, "R6 frz_ack set");
    chk(not_rdy_o, 1'b1, "R6 not_rdy set");
    tx_eng_i = 1'b0; idle(2);
    chk(tx_o, 1'b1, "R7 tx recessive while frozen");
    tx_eng_i = 1'b1;
  endtask

  task automatic t_unfreeze();
    bus_idle_i = 1'b0;
    wr(1'b0, 1'b1, 1'b0, 1'b0);
    idle(30);
    chk(eng_en_o, 1'b1, "R8 engine re-enabled");
    chk(frz_ack_o, 1'b0, "R8 frz_ack cleared");
    chk(not_rdy_o, 1'b1, "R8 not_rdy held without idle");
    bus_idle_i = 1'b1; idle(30);
    chk(not_rdy_o, 1'b0, "R8 ready after idle report");
  endtask

  task automatic t_srst();
    int cyc = 0;
    srst_pulses = 0;
    wr(1'b0, 1'b0, 1'b0, 1'b1);
    chk(srst_o, 1'b1, "R3 srst pending");
    chk(halt_o, 1'b1, "R3 halt forced");
    chk(frz_en_o, 1'b1, "R3 frz_en forced");
    chk(mdis_o, 1'b0, "R3 mdis kept");
    wr(1'b1, 1'b0, 1'b0, 1'b0);
    chk(srst_o, 1'b1, "R4 still pending after 2 cycles");
    chk(mdis_o, 1'b0, "R5 write ignored mdis");
    chk(halt_o, 1'b1, "R5 write ignored halt");
    while (srst_o && cyc < 100) begin idle(1); cyc++; end
    chk(srst_o, 1'b0, "R4 srst self-clears");
    chk(srst_pulses > 0, 1'b1, "R4 engine reset pulse");
    idle(30);
    chk(eng_en_o, 1'b0, "R3 frozen after soft reset");
    chk(frz_ack_o, 1'b1, "R3 frz_ack after soft reset");
  endtask

  task automatic t_mdis();
    wr(1'b1, 1'b1, 1'b1, 1'b0);
    idle(30);
    chk(mdis_o, 1'b1, "R9 mdis set");
    chk(eng_en_o, 1'b0, "R9 engine off");
    chk(frz_ack_o, 1'b0, "R9 frz_ack clear");
    chk(not_rdy_o, 1'b1, "R9 not_rdy set");
  endtask

  initial begin
    idle(3);
    rst_ni = 1'b1;
    t_reset();
    t_enable();
    t_halt_only();
    t_freeze();
    t_unfreeze();
    t_srst();
    t_mdis();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule